// File: doc/BRIEF.md
# Ethernet receive address filter

This block sits beside a receive MAC and decides, frame by frame, whether an incoming frame should be kept. Bytes arrive one per cycle with a start-of-frame marker on the first byte and an end marker on the last. The first six bytes form the 48-bit destination address. The block compares that address against a programmed station address, recognises the all-ones broadcast address, and looks group (multicast) addresses up in a 64-bit hash table indexed by a CRC of the address.

Two results are produced. An early address verdict appears one cycle after the sixth byte, so that the storage path can start or skip buffering. A final verdict appears one cycle after the last byte. It re-applies the short-frame policy and the error policy, using the frame length counted by the block and an error flag delivered with the last byte. The error flag comes from the MAC's CRC and alignment checker. Both verdicts also state whether the address matched as a physical (individual) address or as a group address, for use in a receive status byte.

Policy comes from a 5-bit configuration input. Bit 0 keeps errored frames. Bit 1 keeps short frames. Bit 2 admits broadcast. Bit 3 enables the multicast hash. Bit 4 admits any physical destination (promiscuous mode).

Top module: `rx_addr_filter`

## Requirements
- R1: After a synchronous active-low reset, all six outputs are 0.
- R2: `addr_valid_o` pulses for exactly one cycle. The pulse falls in the cycle after the clock edge that takes the sixth byte of a frame. A byte taken with `sof_i`=1 counts as byte 0 and restarts the count. Destination byte k is the k-th byte on the wire and is compared with `station_i[8k+7:8k]`.
- R3: A physical destination (bit 0 of byte 0 is 0) with `cfg_i[4]`=0 is a hit only when all 48 bits equal `station_i`.
- R4: With `cfg_i[4]`=1, every physical destination is a hit. Group destinations are not affected by this bit.
- R5: The all-ones destination is a hit exactly when `cfg_i[2]`=1.
- R6: For a group destination that is not all ones, the hit is `cfg_i[3]` AND `hash_i[idx]`. The index idx is found as follows. Start a 32-bit register c at all ones. For each of the 48 destination bits, taken byte 0 first and each byte LSB first, set fb = c[0] XOR the data bit, shift c right by one, and XOR c with 0xEDB88320 when fb is 1. After the last bit, idx = c[31:26].
- R7: `addr_grp_o` and `frame_grp_o` are 0 for a physical match and 1 for a group (multicast or broadcast) destination. Both are valid only alongside their valid strobe.
- R8: `frame_valid_o` pulses in the cycle after the edge that takes a byte with `eof_i`=1. `frame_accept_o` can be 1 only in that cycle, and only if the address was a hit.
- R9: A frame of fewer than 64 bytes, counted from byte 0 up to and including the last byte, is rejected unless `cfg_i[1]`=1.
- R10: A frame whose last byte carries `err_i`=1 is rejected unless `cfg_i[0]`=1.
- R11: A frame that ends before its sixth byte is always rejected, and no address verdict is issued for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_i | input | 5 | Policy bits: 0 keep errored, 1 keep short, 2 broadcast, 3 multicast hash, 4 promiscuous |
| station_i | input | 48 | Station address, byte 0 in bits 7:0 |
| hash_i | input | 64 | Multicast hash bit array |
| byte_valid_i | input | 1 | A frame byte is present this cycle |
| sof_i | input | 1 | Present byte is byte 0 of a frame |
| eof_i | input | 1 | Present byte is the last of the frame |
| err_i | input | 1 | CRC or alignment error, sampled with the last byte |
| byte_i | input | 8 | Frame byte |
| addr_valid_o | output | 1 | Address verdict strobe |
| addr_hit_o | output | 1 | Destination address accepted |
| addr_grp_o | output | 1 | Destination is a group address |
| frame_valid_o | output | 1 | Final verdict strobe |
| frame_accept_o | output | 1 | Frame accepted |
| frame_grp_o | output | 1 | Accepted/judged frame has a group destination |

## Verification
A frame of exactly six bytes makes the address verdict and the final verdict fall in the same cycle. The final verdict must then use the address match computed from the byte that has only just arrived. The bench sends such a six-byte frame, with short frames allowed and promiscuous mode on. Its reference model predicts both strobes for that same cycle, and the bench compares all six outputs there. A match taken from a stale address, or a strobe that has slipped by one cycle, shows up as a mismatch.

// File: rtl/rxf_pkg.sv
// Shared constants and the CRC step used for the multicast hash index.
// Assumes reflected CRC-32 processing, least significant bit first.
package rxf_pkg;
    localparam int CFG_W        = 5;
    localparam int CFG_KEEP_ERR = 0;
    localparam int CFG_KEEP_RUNT = 1;
    localparam int CFG_BCAST    = 2;
    localparam int CFG_MCAST    = 3;
    localparam int CFG_PROMISC  = 4;
    localparam logic [31:0] CRC_POLY_REFL = 32'hEDB88320;

    // Advance the CRC register by one byte, LSB first.
    function automatic logic [31:0] crc_byte(input logic [31:0] c, input logic [7:0] d);
        logic [31:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_REFL;
            else             r = r >> 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/rxf_dest_capture.sv
// Counts frame bytes, captures the destination bytes, and runs the CRC over them.
// Assumes sof_i is only looked at when byte_valid_i is set. Counter saturates.
module rxf_dest_capture #(
    parameter int ADDR_BYTES = 6,
    parameter int LEN_W      = 16,
    parameter int IDX_W      = 6
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_valid_i,
    input  logic                    sof_i,
    input  logic [7:0]              byte_i,
    output logic [8*ADDR_BYTES-1:0] dest_o,
    output logic [IDX_W-1:0]        hash_idx_o,
    output logic [LEN_W-1:0]        len_o,
    output logic                    done_o
);
    import rxf_pkg::*;

    localparam logic [LEN_W-1:0] LAST_POS = LEN_W'(ADDR_BYTES - 1);
    localparam logic [LEN_W-1:0] NUM_POS  = LEN_W'(ADDR_BYTES);

    logic [LEN_W-1:0] cnt_q;
    logic [LEN_W-1:0] pos;
    logic [31:0]      crc_q;
    logic             done_q;
    logic [7:0]       lane_q [ADDR_BYTES];

    // Position of the byte present this cycle.
    assign pos = sof_i ? '0 : cnt_q;

    // Byte counter: restarts on sof, otherwise counts up and saturates.
    always_ff @(posedge clk) begin
        if (!rst_n)                 cnt_q <= '0;
        else if (byte_valid_i) begin
            if (sof_i)              cnt_q <= LEN_W'(1);
            else if (cnt_q != '1)   cnt_q <= cnt_q + 1'b1;
        end
    end

    // CRC over destination bytes, reseeded at every frame start.
    always_ff @(posedge clk) begin
        if (!rst_n)                                crc_q <= '1;
        else if (byte_valid_i && pos < NUM_POS)    crc_q <= crc_byte(sof_i ? '1 : crc_q, byte_i);
    end

    // Completion strobe: the last destination byte was just taken.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= byte_valid_i && (pos == LAST_POS);
    end

    // One capture register per destination byte lane.
    for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_lane
        localparam logic [LEN_W-1:0] LANE = LEN_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n)                              lane_q[g] <= '0;
            else if (byte_valid_i && pos == LANE)    lane_q[g] <= byte_i;
        end
        assign dest_o[8*g +: 8] = lane_q[g];
    end

    assign hash_idx_o = crc_q[31 -: IDX_W];
    assign len_o      = cnt_q;
    assign done_o     = done_q;

    // R2: the address verdict strobe never lasts two cycles.
    p_done_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
endmodule

// File: rtl/rxf_addr_match.sv
// Combinational address classification and match against station, broadcast and hash.
// Assumes dest_i and idx_i are stable once the sixth byte is taken.
module rxf_addr_match #(
    parameter int ADDR_W = 48,
    parameter int HASH_W = 64,
    parameter int IDX_W  = 6
) (
    input  logic [rxf_pkg::CFG_W-1:0] cfg_i,
    input  logic [ADDR_W-1:0]         dest_i,
    input  logic [ADDR_W-1:0]         station_i,
    input  logic [HASH_W-1:0]         hash_i,
    input  logic [IDX_W-1:0]          idx_i,
    output logic                      hit_o,
    output logic                      grp_o
);
    import rxf_pkg::*;

    logic is_grp;
    logic is_bcast;

    // Classify the destination and apply the policy bit for its class.
    always_comb begin
        is_grp   = dest_i[0];
        is_bcast = &dest_i;
        if (is_bcast)     hit_o = cfg_i[CFG_BCAST];
        else if (is_grp)  hit_o = cfg_i[CFG_MCAST] & hash_i[idx_i];
        else              hit_o = cfg_i[CFG_PROMISC] | (dest_i == station_i);
        grp_o = is_grp;
    end
endmodule

// File: rtl/rxf_frame_judge.sv
// End-of-frame verdict: applies length and error policies to the address match.
// Assumes len_i holds the final length in the cycle after the last byte.
module rxf_frame_judge #(
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64,
    parameter int ADDR_BYTES = 6
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      last_i,
    input  logic                      err_i,
    input  logic [rxf_pkg::CFG_W-1:0] cfg_i,
    input  logic [LEN_W-1:0]          len_i,
    input  logic                      addr_hit_i,
    input  logic                      addr_grp_i,
    output logic                      valid_o,
    output logic                      accept_o,
    output logic                      grp_o
);
    import rxf_pkg::*;

    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(MIN_LEN);
    localparam logic [LEN_W-1:0] ADDR_L = LEN_W'(ADDR_BYTES);

    logic fin_q;
    logic err_q;
    logic have_addr;
    logic len_ok;
    logic err_ok;

    // Capture the end-of-frame event and its error flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fin_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            fin_q <= last_i;
            if (last_i) err_q <= err_i;
        end
    end

    // Combine address match with length and error policy.
    always_comb begin
        have_addr = len_i >= ADDR_L;
        len_ok    = (len_i >= MIN_L) | cfg_i[CFG_KEEP_RUNT];
        err_ok    = !err_q | cfg_i[CFG_KEEP_ERR];
        valid_o   = fin_q;
        accept_o  = fin_q & have_addr & addr_hit_i & len_ok & err_ok;
        grp_o     = fin_q & have_addr & addr_grp_i;
    end

    // R10: an errored frame is never accepted without the keep-errored bit.
    p_err_drop_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !cfg_i[CFG_KEEP_ERR]) |-> !$past(err_i));
    // R9: a short frame is never accepted without the keep-short bit.
    p_runt_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (accept_o && !cfg_i[CFG_KEEP_RUNT]) |-> (len_i >= MIN_L));
    // R8: acceptance only follows a last byte.
    p_accept_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
        accept_o |-> $past(last_i));
endmodule

// File: rtl/rx_addr_filter.sv
// Receive address filter top: byte capture, address match and frame verdict.
// Assumes one byte per cycle, sof_i on byte 0, eof_i and err_i on the last byte.
module rx_addr_filter #(
    parameter int ADDR_BYTES = 6,
    parameter int HASH_W     = 64,
    parameter int LEN_W      = 16,
    parameter int MIN_LEN    = 64
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [rxf_pkg::CFG_W-1:0] cfg_i,
    input  logic [8*ADDR_BYTES-1:0]   station_i,
    input  logic [HASH_W-1:0]         hash_i,
    input  logic                      byte_valid_i,
    input  logic                      sof_i,
    input  logic                      eof_i,
    input  logic                      err_i,
    input  logic [7:0]                byte_i,
    output logic                      addr_valid_o,
    output logic                      addr_hit_o,
    output logic                      addr_grp_o,
    output logic                      frame_valid_o,
    output logic                      frame_accept_o,
    output logic                      frame_grp_o
);
    localparam int ADDR_W = 8 * ADDR_BYTES;
    localparam int IDX_W  = $clog2(HASH_W);

    logic [ADDR_W-1:0] dest;
    logic [IDX_W-1:0]  idx;
    logic [LEN_W-1:0]  len;
    logic              done;
    logic              hit;
    logic              grp;

    rxf_dest_capture #(.ADDR_BYTES(ADDR_BYTES), .LEN_W(LEN_W), .IDX_W(IDX_W)) u_cap (
        .clk(clk), .rst_n(rst_n), .byte_valid_i(byte_valid_i), .sof_i(sof_i),
        .byte_i(byte_i), .dest_o(dest), .hash_idx_o(idx), .len_o(len), .done_o(done)
    );

    rxf_addr_match #(.ADDR_W(ADDR_W), .HASH_W(HASH_W), .IDX_W(IDX_W)) u_match (
        .cfg_i(cfg_i), .dest_i(dest), .station_i(station_i), .hash_i(hash_i),
        .idx_i(idx), .hit_o(hit), .grp_o(grp)
    );

    rxf_frame_judge #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN), .ADDR_BYTES(ADDR_BYTES)) u_judge (
        .clk(clk), .rst_n(rst_n), .last_i(byte_valid_i & eof_i), .err_i(err_i),
        .cfg_i(cfg_i), .len_i(len), .addr_hit_i(hit), .addr_grp_i(grp),
        .valid_o(frame_valid_o), .accept_o(frame_accept_o), .grp_o(frame_grp_o)
    );

    // Early verdict is the live match, gated to the strobe cycle.
    assign addr_valid_o = done;
    assign addr_hit_o   = done & hit;
    assign addr_grp_o   = done & grp;

    // R8: no acceptance without a final verdict strobe.
    p_accept_needs_valid_r8: assert property (@(posedge clk) disable iff (!rst_n)
        frame_accept_o |-> frame_valid_o);
endmodule

// File: tb/rx_addr_filter_tb_top.sv
module rx_addr_filter_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [4:0]  cfg = '0;
    logic [47:0] station = 48'hAB8967452302;
    logic [63:0] hash = '0;
    logic        bv = 1'b0, sof = 1'b0, eof = 1'b0, err = 1'b0;
    logic [7:0]  bdat = '0;
    logic av, ah, ag, fv, fa, fg;

    int checks = 0, errors = 0, cyc = 0;
    string cur_tag = "R3";
    logic started = 1'b0;

    // Reference model state
    int   m_cnt = 0;
    logic [7:0] m_q[$];
    logic e_av = 0, e_ah = 0, e_ag = 0, e_fv = 0, e_fa = 0, e_fg = 0;
    logic m_hit = 0, m_grp = 0;

    always #10 clk = ~clk;

    rx_addr_filter dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_i(cfg), .station_i(station), .hash_i(hash),
        .byte_valid_i(bv), .sof_i(sof), .eof_i(eof), .err_i(err), .byte_i(bdat),
        .addr_valid_o(av), .addr_hit_o(ah), .addr_grp_o(ag),
        .frame_valid_o(fv), .frame_accept_o(fa), .frame_grp_o(fg)
    );

    function automatic logic [5:0] ref_idx(input logic [47:0] d);
        logic [31:0] c;
        logic fb;
        c = 32'hFFFF_FFFF;
        for (int b = 0; b < 48; b++) begin
            fb = c[0] ^ d[b];
            c  = {1'b0, c[31:1]};
            if (fb) c = c ^ 32'hEDB88320;
        end
        return c[31:26];
    endfunction

    function automatic logic ref_hit(input logic [47:0] d);
        if (d == 48'hFFFF_FFFF_FFFF) return cfg[2];
        if (d[0]) return cfg[3] && hash[ref_idx(d)];
        return cfg[4] || (d == station);
    endfunction

    // Behavioural model, advanced on each clock edge.
    always @(posedge clk) begin
        logic [47:0] d;
        e_av = 0; e_ah = 0; e_ag = 0; e_fv = 0; e_fa = 0; e_fg = 0;
        if (rst_n && bv) begin
            if (sof) begin m_cnt = 1; m_q.delete(); end
            else m_cnt++;
            if (m_q.size() < 6) begin
                m_q.push_back(bdat);
                if (m_q.size() == 6) begin
                    for (int k = 0; k < 6; k++) d[8*k +: 8] = m_q[k];
                    m_hit = ref_hit(d);
                    m_grp = d[0];
                    e_av = 1; e_ah = m_hit; e_ag = m_grp;
                end
            end
            if (eof) begin
                e_fv = 1;
                e_fa = (m_cnt >= 6) && m_hit && (m_cnt >= 64 || cfg[1]) && (!err || cfg[0]);
                e_fg = (m_cnt >= 6) && m_grp;
            end
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp, input string what);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b at cycle %0d", tag, what, act, exp, cyc);
        end
    endtask

    // Compare every output against the model away from the clock edge.
    always @(negedge clk) begin
        if (started) begin
            chk("R2", av, e_av, "addr_valid");
            chk(cur_tag, ah, e_ah, "addr_hit");
            chk("R7", ag, e_ag, "addr_grp");
            chk("R8", fv, e_fv, "frame_valid");
            chk(cur_tag, fa, e_fa, "frame_accept");
            chk("R7", fg, e_fg, "frame_grp");
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc == 100000) begin
            errors++;
            $display("FAIL R8 watchdog actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic send(input string tag, input logic [47:0] d, input int len,
                        input logic e, input logic do_eof);
        cur_tag = tag;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            bv   = 1'b1;
            sof  = (i == 0);
            eof  = do_eof && (i == len - 1);
            err  = e && (i == len - 1);
            bdat = (i < 6) ? d[8*i +: 8] : 8'(i);
        end
        @(negedge clk);
        bv = 1'b0; sof = 1'b0; eof = 1'b0; err = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    initial begin
        logic [47:0] mc;
        mc = 48'h3C2B1A00FF01;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk("R1", av | ah | ag | fv | fa | fg, 1'b0, "outputs after reset");
        started = 1'b1;

        cfg = 5'b00000;
        send("R3", station, 64, 0, 1);                  // exact match
        send("R3", station ^ 48'h0100_0000_0000, 70, 0, 1); // last byte differs
        send("R3", station ^ 48'h0000_0000_0200, 64, 0, 1); // second byte differs
        cfg = 5'b10000;
        send("R4", 48'h00000000AA10, 64, 0, 1);          // promiscuous physical
        send("R4", mc, 64, 0, 1);                        // group unaffected
        cfg = 5'b00100;
        send("R5", 48'hFFFF_FFFF_FFFF, 64, 0, 1);
        cfg = 5'b00000;
        send("R5", 48'hFFFF_FFFF_FFFF, 64, 0, 1);
        cfg = 5'b01000;
        hash = 64'd1 << ref_idx(mc);
        send("R6", mc, 64, 0, 1);                        // hash bit set
        hash = ~(64'd1 << ref_idx(mc));
        send("R6", mc, 64, 0, 1);                        // only other bits set
        cfg = 5'b00000;
        hash = '1;
        send("R6", mc, 64, 0, 1);                        // hash disabled
        cfg = 5'b00000;
        send("R9", station, 63, 0, 1);                   // one short of minimum
        send("R9", station, 40, 0, 1);
        cfg = 5'b00010;
        send("R9", station, 40, 0, 1);
        cfg = 5'b00000;
        send("R10", station, 64, 1, 1);
        cfg = 5'b00001;
        send("R10", station, 64, 1, 1);
        cfg = 5'b10010;
        send("R11", station, 4, 0, 1);                   // ends before address complete
        send("R11", station, 3, 0, 0);                   // abandoned, then restart
        send("R7", station, 6, 0, 1);                    // both verdicts in one cycle
        cfg = 5'b01110;
        send("R7", mc, 6, 0, 1);
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule